// File: doc/BRIEF.md
# Dual-Half Programmable Interval Timer

This peripheral holds two 32-bit counting halves, low and high, that run independently from a common tick enable. Each half has a counter and a period register. A shared timer-control word carries a two-bit enable mode for each half. A global-control word carries a per-half release bit and a two-bit mode that chooses how the halves combine. Software reaches every register through a single-cycle register bus. Writes take effect on the clock edge. Reads are combinational from the address.

Each released half counts one step per cycle in which `tick` is high. In periodic mode it wraps to zero after matching its period. With a period of all ones this makes it a free-running 32-bit time source. In one-shot mode it stops on the period value and clears its own enable field. Only the split (dual unchained) combine mode lets the halves count. The other mode codes are stored but hold both counters.

Top module: `dual_half_timer`

## Requirements
- R1: After reset every register reads zero, except the identity word at offset 0x00, which reads the `ID_VALUE` parameter.
- R2: Offsets other than 0x00, 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 read zero. A write to such an offset changes no register.
- R3: Global control at 0x24 reads back bits [3:0]. Bit 0 releases the low half and bit 1 releases the high half; 0 holds that half in reset. A held half's counter becomes zero on the next edge, it ignores its enable field, and writes to its counter are discarded.
- R4: Global control bits [3:2] select the combine mode: 0 = wide, 1 = split, 2 = guarded, 3 = linked. Counters advance only when the code is 1. Any other code freezes both counters.
- R5: In periodic mode (enable code 2), each tick raises the counter by one. A tick taken while the counter equals the period sets it to zero.
- R6: In one-shot mode (enable code 1), the counter advances on each tick until it equals the period and then holds. On the tick that brings it to the period, that half's enable field becomes 0.
- R7: Enable code 0 freezes the counter at its current value, and reads return that value. Reserved code 3 behaves the same way and reads back as 3.
- R8: A bus write to a released half's counter (low 0x10, high 0x14) loads the written value on that edge. It takes priority over a tick in the same cycle.
- R9: In timer control at 0x20, the low half's enable field is bits [7:6] and the high half's is bits [23:22]. All other bits read zero.
- R10: With the period at 0xFFFFFFFF in periodic mode, the counter passes from 0xFFFFFFFF to 0 and keeps counting up.
- R11: The halves are independent. A tick, mode or reset bit acting on one half does not alter the other half's counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; one step per cycle while high |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The bench drives a one-shot half through its final tick and checks three things: the enable field clears, and the counter neither passes the period nor restarts. A design that rechecks against the period one cycle late would overshoot by one. A design that leaves the field set would keep looping.

The periodic half is taken around its wrap, including the all-ones period crossing zero. This catches an off-by-one wrap or a compare against period+1.

The bench also covers several cases that a careless design gets wrong:
- A half held in reset must zero its counter and drop a counter write.
- Non-split mode codes must freeze counting.
- Reserved enable code 3 must not count.
- A counter write and a tick in the same cycle must favour the write.

Each of these is checked at the read port, together with the other half's counter, so leakage between the halves is caught.

// File: rtl/dht_pkg.sv
package dht_pkg;

    localparam int unsigned NUM_HALVES = 2;
    localparam int unsigned DATA_W     = 32;

    // register offsets
    localparam int unsigned OFS_ID   = 'h00;
    localparam int unsigned OFS_TCTL = 'h20;
    localparam int unsigned OFS_GCTL = 'h24;

    typedef enum logic [1:0] {
        EN_OFF  = 2'd0,
        EN_ONCE = 2'd1,
        EN_LOOP = 2'd2,
        EN_RSVD = 2'd3
    } en_mode_e;

    typedef enum logic [1:0] {
        TM_WIDE   = 2'd0,
        TM_SPLIT  = 2'd1,
        TM_GUARD  = 2'd2,
        TM_LINKED = 2'd3
    } tmode_e;

    // global control word: [3:2] combine mode, [1:0] per-half release
    typedef struct packed {
        tmode_e          mode;
        logic [NUM_HALVES-1:0] rel;
    } gctl_t;

    function automatic int unsigned cnt_ofs(input int unsigned h);
        return 'h10 + 4 * h;
    endfunction

    function automatic int unsigned prd_ofs(input int unsigned h);
        return 'h18 + 4 * h;
    endfunction

    function automatic int unsigned en_pos(input int unsigned h);
        return (h == 0) ? 6 : 22;
    endfunction

endpackage

// File: rtl/dht_half.sv
module dht_half
    import dht_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             released,
    input  logic             split_mode,
    input  logic [1:0]       mode_raw,
    input  logic             cnt_we,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd,
    output logic             once_done
);

    en_mode_e         mode;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;
    logic             at_end;
    logic             active;

    assign mode    = en_mode_e'(mode_raw);
    assign cnt_inc = cnt + CNT_W'(1);
    assign at_end  = (cnt == prd);
    assign active  = released && split_mode && tick;

    always_comb begin
        cnt_nxt   = cnt;
        once_done = 1'b0;
        if (!released) begin
            cnt_nxt = '0;
        end else if (cnt_we) begin
            cnt_nxt = ld_data;
        end else if (active) begin
            case (mode)
                EN_LOOP: cnt_nxt = at_end ? '0 : cnt_inc;
                EN_ONCE: begin
                    if (!at_end) cnt_nxt = cnt_inc;
                    once_done = at_end || (cnt_inc == prd);
                end
                default: cnt_nxt = cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            prd <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (prd_we) prd <= ld_data;
        end
    end

    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !released |=> cnt == '0); // R3

    AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        active && !cnt_we && mode == EN_LOOP && cnt == prd |=> cnt == '0); // R5

    AST_LOOP_STEP: assert property (@(posedge clk) disable iff (rst)
        active && !cnt_we && mode == EN_LOOP && cnt != prd
        |=> cnt == $past(cnt) + CNT_W'(1)); // R5

    AST_ONCE_STOP: assert property (@(posedge clk) disable iff (rst)
        active && !cnt_we && mode == EN_ONCE && cnt == prd |=> $stable(cnt)); // R6

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        released && !cnt_we && (mode == EN_OFF || mode == EN_RSVD)
        |=> $stable(cnt)); // R7

    AST_NONSPLIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        released && !split_mode && !cnt_we |=> $stable(cnt)); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        released && cnt_we |=> cnt == $past(ld_data)); // R8

endmodule

// File: rtl/dht_regfile.sv
module dht_regfile
    import dht_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CNT_W    = 32,
    parameter logic [31:0] ID_VALUE = 32'h0001_0C3A
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic [NUM_HALVES-1:0][CNT_W-1:0] cnt_q,
    input  logic [NUM_HALVES-1:0][CNT_W-1:0] prd_q,
    input  logic [NUM_HALVES-1:0]            once_done,
    output logic [NUM_HALVES-1:0][1:0]       en_mode,
    output logic [NUM_HALVES-1:0]            released,
    output logic                             split_mode,
    output logic [NUM_HALVES-1:0]            cnt_we,
    output logic [NUM_HALVES-1:0]            prd_we,
    output logic [CNT_W-1:0]                 ld_data,
    output logic [DATA_W-1:0]                bus_rdata
);

    localparam int unsigned GC_W = $bits(gctl_t);

    gctl_t                       gc_q;
    logic [NUM_HALVES-1:0][1:0]  en_q;
    logic                        tctl_wr;
    logic                        gctl_wr;
    logic [DATA_W-1:0]           tctl_view;

    assign tctl_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_TCTL));
    assign gctl_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_GCTL));
    assign ld_data    = bus_wdata[CNT_W-1:0];
    assign en_mode    = en_q;
    assign released   = gc_q.rel;
    assign split_mode = (gc_q.mode == TM_SPLIT);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_dec
        assign cnt_we[h] = bus_wr && (bus_addr == ADDR_W'(cnt_ofs(h)));
        assign prd_we[h] = bus_wr && (bus_addr == ADDR_W'(prd_ofs(h)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gc_q <= '0;
            en_q <= '0;
        end else begin
            if (gctl_wr) gc_q <= gctl_t'(bus_wdata[GC_W-1:0]);
            for (int h = 0; h < NUM_HALVES; h++) begin
                if (tctl_wr) en_q[h] <= bus_wdata[en_pos(h) +: 2];
                else if (once_done[h]) en_q[h] <= EN_OFF;
            end
        end
    end

    always_comb begin
        tctl_view = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            tctl_view[en_pos(h) +: 2] = en_q[h];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_ID))   bus_rdata = ID_VALUE;
        if (bus_addr == ADDR_W'(OFS_TCTL)) bus_rdata = tctl_view;
        if (bus_addr == ADDR_W'(OFS_GCTL)) bus_rdata = DATA_W'(gc_q);
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (bus_addr == ADDR_W'(cnt_ofs(h))) bus_rdata = DATA_W'(cnt_q[h]);
            if (bus_addr == ADDR_W'(prd_ofs(h))) bus_rdata = DATA_W'(prd_q[h]);
        end
    end

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
        AST_ONCE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            once_done[h] && !tctl_wr |=> en_q[h] == EN_OFF); // R6
    end

    AST_GC_READBACK: assert property (@(posedge clk) disable iff (rst)
        gctl_wr |=> GC_W'(gc_q) == $past(bus_wdata[GC_W-1:0])); // R3

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !tctl_wr && !gctl_wr && cnt_we == '0 && prd_we == '0
        |=> $stable(gc_q) && $stable(en_q)); // R2

endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
    import dht_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CNT_W    = 32,
    parameter logic [31:0] ID_VALUE = 32'h0001_0C3A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    logic [NUM_HALVES-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_HALVES-1:0][CNT_W-1:0] prd_q;
    logic [NUM_HALVES-1:0]            once_done;
    logic [NUM_HALVES-1:0][1:0]       en_mode;
    logic [NUM_HALVES-1:0]            released;
    logic                             split_mode;
    logic [NUM_HALVES-1:0]            cnt_we;
    logic [NUM_HALVES-1:0]            prd_we;
    logic [CNT_W-1:0]                 ld_data;

    dht_regfile #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_q      (cnt_q),
        .prd_q      (prd_q),
        .once_done  (once_done),
        .en_mode    (en_mode),
        .released   (released),
        .split_mode (split_mode),
        .cnt_we     (cnt_we),
        .prd_we     (prd_we),
        .ld_data    (ld_data),
        .bus_rdata  (bus_rdata)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        dht_half #(
            .CNT_W (CNT_W)
        ) u_half (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .released   (released[h]),
            .split_mode (split_mode),
            .mode_raw   (en_mode[h]),
            .cnt_we     (cnt_we[h]),
            .prd_we     (prd_we[h]),
            .ld_data    (ld_data),
            .cnt        (cnt_q[h]),
            .prd        (prd_q[h]),
            .once_done  (once_done[h])
        );
    end

endmodule

// File: tb/dual_half_timer_tb.sv
module dual_half_timer_tb;

    localparam logic [31:0] TB_ID = 32'h0001_0C3A;
    localparam int NV = 64;

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 check, 2 tick burst
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h00, TB_ID,        8'd1},  // R1 identity
        '{2'd1, 8'h10, 32'h0,        8'd1},  // R1
        '{2'd1, 8'h14, 32'h0,        8'd1},  // R1
        '{2'd1, 8'h18, 32'h0,        8'd1},  // R1
        '{2'd1, 8'h1C, 32'h0,        8'd1},  // R1
        '{2'd1, 8'h20, 32'h0,        8'd1},  // R1
        '{2'd1, 8'h24, 32'h0,        8'd1},  // R1
        '{2'd0, 8'h24, 32'h7,        8'd3},  // R3 split mode, both released
        '{2'd1, 8'h24, 32'h7,        8'd3},  // R3
        '{2'd0, 8'h18, 32'h5,        8'd5},  // R5 low period
        '{2'd0, 8'h1C, 32'h3,        8'd6},  // R6 high period
        '{2'd0, 8'h20, 32'h0040_0080, 8'd9}, // R9 low periodic, high one-shot
        '{2'd1, 8'h20, 32'h0040_0080, 8'd9}, // R9
        '{2'd2, 8'h00, 32'd4,        8'd5},  // R5
        '{2'd1, 8'h10, 32'd4,        8'd5},  // R5
        '{2'd1, 8'h14, 32'd3,        8'd6},  // R6 held at period
        '{2'd1, 8'h20, 32'h0000_0080, 8'd6}, // R6 high field cleared
        '{2'd2, 8'h00, 32'd2,        8'd5},  // R5
        '{2'd1, 8'h10, 32'd0,        8'd5},  // R5 wrap
        '{2'd1, 8'h14, 32'd3,        8'd6},  // R6
        '{2'd2, 8'h00, 32'd3,        8'd5},  // R5
        '{2'd0, 8'h20, 32'h0000_00C0, 8'd7}, // R7 reserved code
        '{2'd2, 8'h00, 32'd3,        8'd7},  // R7
        '{2'd1, 8'h10, 32'd3,        8'd7},  // R7
        '{2'd1, 8'h20, 32'h0000_00C0, 8'd7}, // R7
        '{2'd0, 8'h20, 32'h0,        8'd7},  // R7 disabled
        '{2'd2, 8'h00, 32'd2,        8'd7},  // R7
        '{2'd1, 8'h10, 32'd3,        8'd7},  // R7
        '{2'd0, 8'h20, 32'h0000_0080, 8'd4}, // R4
        '{2'd0, 8'h24, 32'h3,        8'd4},  // R4 wide mode
        '{2'd2, 8'h00, 32'd3,        8'd4},  // R4
        '{2'd1, 8'h10, 32'd3,        8'd4},  // R4
        '{2'd0, 8'h24, 32'hB,        8'd4},  // R4 guarded mode
        '{2'd2, 8'h00, 32'd2,        8'd4},  // R4
        '{2'd1, 8'h10, 32'd3,        8'd4},  // R4
        '{2'd0, 8'h24, 32'h7,        8'd4},  // R4 split again
        '{2'd2, 8'h00, 32'd1,        8'd4},  // R4
        '{2'd1, 8'h10, 32'd4,        8'd4},  // R4
        '{2'd0, 8'h24, 32'h6,        8'd3},  // R3 hold low half
        '{2'd2, 8'h00, 32'd2,        8'd3},  // R3
        '{2'd1, 8'h10, 32'd0,        8'd3},  // R3
        '{2'd1, 8'h14, 32'd3,        8'd11}, // R11 high untouched
        '{2'd0, 8'h10, 32'd9,        8'd3},  // R3 write while held
        '{2'd1, 8'h10, 32'd0,        8'd3},  // R3
        '{2'd0, 8'h24, 32'h7,        8'd3},  // R3 release
        '{2'd2, 8'h00, 32'd2,        8'd3},  // R3
        '{2'd1, 8'h10, 32'd2,        8'd3},  // R3
        '{2'd0, 8'h10, 32'd1,        8'd8},  // R8
        '{2'd1, 8'h10, 32'd1,        8'd8},  // R8
        '{2'd2, 8'h00, 32'd1,        8'd8},  // R8
        '{2'd1, 8'h10, 32'd2,        8'd8},  // R8
        '{2'd0, 8'h1C, 32'hFFFF_FFFF, 8'd10}, // R10
        '{2'd0, 8'h14, 32'hFFFF_FFFE, 8'd10}, // R10
        '{2'd0, 8'h20, 32'h0080_0080, 8'd10}, // R10 both periodic
        '{2'd2, 8'h00, 32'd3,        8'd10}, // R10
        '{2'd1, 8'h14, 32'd1,        8'd10}, // R10 crossed zero
        '{2'd1, 8'h10, 32'd5,        8'd11}, // R11
        '{2'd0, 8'h28, 32'hFFFF_FFFF, 8'd2}, // R2
        '{2'd0, 8'h04, 32'h0000_1234, 8'd2}, // R2
        '{2'd1, 8'h28, 32'h0,        8'd2},  // R2
        '{2'd1, 8'h04, 32'h0,        8'd2},  // R2
        '{2'd1, 8'h20, 32'h0080_0080, 8'd2}, // R2
        '{2'd1, 8'h24, 32'h7,        8'd2},  // R2
        '{2'd1, 8'h1C, 32'hFFFF_FFFF, 8'd2}  // R2
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dual_half_timer #(
        .ADDR_W   (8),
        .CNT_W    (32),
        .ID_VALUE (TB_ID)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic check(input logic [7:0] a, input logic [31:0] exp, input int req);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d addr=%02h actual=%08h expected=%08h", req, a, bus_rdata, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: do_write(VECS[i].addr, VECS[i].data);
                2'd1: check(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
                default: do_ticks(int'(VECS[i].data));
            endcase
        end

        // R8: write and tick in the same cycle, write wins; high keeps ticking (R11)
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd100; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0; bus_wdata = '0;
        check(8'h10, 32'd100, 8);  // R8
        check(8'h14, 32'd2, 11);   // R11

        // R1: reset in mid-run returns everything to its initial state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(8'h00, TB_ID, 1);    // R1
        check(8'h10, 32'h0, 1);    // R1
        check(8'h14, 32'h0, 1);    // R1
        check(8'h1C, 32'h0, 1);    // R1
        check(8'h20, 32'h0, 1);    // R1
        check(8'h24, 32'h0, 1);    // R1

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule